// File: doc/BRIEF.md
# Prescaled Reload Timer with Free-Running Counter

This block is a small register-mapped timer peripheral with two independent engines. The first is a down-counter. A load write seeds both the counter and its reload register. The counter decrements once per prescaled tick. When it is found at zero it raises an interrupt and restarts from the reload value. The tick rate is the system clock divided first by a programmable predivider and then by a selectable 1, 16 or 256. The counter can run 16 or 32 bits wide. It stops while a debug halt input is asserted, if that feature is enabled.

The second engine is a 32-bit up-counter that never reloads. It advances once every N+1 system clocks, with N taken from an 8-bit field of the control word. Software configures both engines through one packed control word and reads their state through a flat array of 32-bit word registers. Reads are combinational from the word index. Writes take effect at the clock edge on which the write enable is high.

Top module: `prescaled_timer`

## Requirements
- R1: After reset every register reads 0 and `irqOut` is low.
- R2: A write to word 0 (load) sets both the counter and the reload value. Word 1 (value) returns the counter and word 0 returns the reload value. A load write resets the predivider and prescale phase.
- R3: The tick period is (P+1)*S clocks. P is word 7 (predivider, low 10 bits). S is chosen by control bits 3:2: 00 gives 1, 01 gives 16, and 10 or 11 gives 256. Starting from the enable or load edge, the raw interrupt sets (P+1)*S*(V+1) clocks after loading V.
- R4: A tick that finds the counter at zero sets the raw interrupt and reloads the counter, so the interrupt repeats with the same period. A write to word 6 (reload) changes only the reload value, which is used at the next wrap.
- R5: Control bit 1 picks the width: 0 gives 16 bits and 1 gives 32 bits. In 16-bit mode, only bits 15:0 of the loaded value count and word 1 reads zero-extended.
- R6: Loading 0 while running with P=0 and S=1 raises the interrupt on the first edge after the load edge.
- R7: Word 5 (masked) and `irqOut` equal the raw flag (word 4, bit 0) AND control bit 5. Any write to word 3 clears the raw flag, whatever the data.
- R8: The down-counter advances only while control bit 7 is set. It also holds while control bit 8 and the `dbgHalt` input are both high.
- R9: Control bit 9 enables the free counter (word 8), which increments once every N+1 clocks, where N is control bits 23:16. When the enable bit is clear, the counter holds its value.
- R10: Words 1, 4, 5 and 8 are read-only, so writes to them have no effect. Word 2 reads back only bits 1, 3:2, 5, 7, 8, 9 and 23:16; all other bits read as 0.
- R11: A control write that clears the enable bits, followed by a write to word 3, leaves `irqOut` low and the counter frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Word register index |
| regWrEn | input | 1 | Write strobe for the indexed word |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data of the indexed word |
| dbgHalt | input | 1 | Debug halt request |
| irqOut | output | 1 | Masked timer interrupt |

## Verification
The countdown is exercised with loads of zero, small and mid-size values. These are swept across all three prescale settings and several predivider values, so a wrong divisor, a missing +1 in either divider, or an off-by-one in the zero detection each shifts the measured interrupt cycle by a distinguishable amount. The second period after a clear separates reload behaviour from load behaviour. A reload-only write mid-count shows whether that write leaks into the running count. The free counter is checked over exact multiples of its divide ratio, from a known phase and in steady state, and again after it is disabled, which tells a wrong ratio apart from a counter that never holds.

// File: rtl/timerPkg.sv
package timerPkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 4;
  localparam int FDIV_W = 8;
  localparam int HALF_W = 16;

  localparam logic [ADDR_W-1:0] IDX_LOAD   = 4'd0;
  localparam logic [ADDR_W-1:0] IDX_VALUE  = 4'd1;
  localparam logic [ADDR_W-1:0] IDX_CTRL   = 4'd2;
  localparam logic [ADDR_W-1:0] IDX_CLEAR  = 4'd3;
  localparam logic [ADDR_W-1:0] IDX_RAW    = 4'd4;
  localparam logic [ADDR_W-1:0] IDX_MASKED = 4'd5;
  localparam logic [ADDR_W-1:0] IDX_RELOAD = 4'd6;
  localparam logic [ADDR_W-1:0] IDX_PREDIV = 4'd7;
  localparam logic [ADDR_W-1:0] IDX_FREE   = 4'd8;

  typedef struct packed {
    logic              width32;
    logic [1:0]        scaleSel;
    logic              irqEn;
    logic              timerEn;
    logic              haltEn;
    logic              freeEn;
    logic [FDIV_W-1:0] freeDiv;
  } ctlFields_t;

  typedef struct packed {
    logic loadWr;
    logic reloadWr;
    logic clrWr;
    logic timerTick;
    logic freeTick;
  } strobes_t;
endpackage

// File: rtl/timerCtrl.sv
module timerCtrl
  import timerPkg::*;
#(
  parameter int PREDIV_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  input  logic                dbgHalt,
  output ctlFields_t          ctlBits,
  output logic [PREDIV_W-1:0] preDiv,
  output strobes_t            strb
);
  localparam logic [PREDIV_W-1:0] PRE_ONE  = 1;
  localparam logic [FDIV_W-1:0]   FDIV_ONE = 1;

  logic [PREDIV_W-1:0] preCnt;
  logic [7:0]          scCnt;
  logic [7:0]          scaleMax;
  logic [FDIV_W-1:0]   fdCnt;
  logic                running;
  logic                baseTick;
  logic                wrCtl;
  logic                wrPre;
  logic                unusedBits;

  assign unusedBits = ^{regWrData[31:24], regWrData[15:10]};

  assign wrCtl = regWrEn && (regAddr == IDX_CTRL);
  assign wrPre = regWrEn && (regAddr == IDX_PREDIV);

  always_comb begin
    case (ctlBits.scaleSel)
      2'b00:   scaleMax = 8'd0;
      2'b01:   scaleMax = 8'd15;
      default: scaleMax = 8'd255;
    endcase
  end

  assign running  = ctlBits.timerEn && !(ctlBits.haltEn && dbgHalt);
  assign baseTick = running && (preCnt >= preDiv);

  always_comb begin
    strb.loadWr    = regWrEn && (regAddr == IDX_LOAD);
    strb.reloadWr  = regWrEn && (regAddr == IDX_RELOAD);
    strb.clrWr     = regWrEn && (regAddr == IDX_CLEAR);
    strb.timerTick = baseTick && (scCnt >= scaleMax);
    strb.freeTick  = ctlBits.freeEn && (fdCnt >= ctlBits.freeDiv);
  end

  // control word and predivider registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlBits <= '0;
      preDiv  <= '0;
    end else begin
      if (wrCtl) begin
        ctlBits.width32  <= regWrData[1];
        ctlBits.scaleSel <= regWrData[3:2];
        ctlBits.irqEn    <= regWrData[5];
        ctlBits.timerEn  <= regWrData[7];
        ctlBits.haltEn   <= regWrData[8];
        ctlBits.freeEn   <= regWrData[9];
        ctlBits.freeDiv  <= regWrData[23:16];
      end
      if (wrPre) preDiv <= regWrData[PREDIV_W-1:0];
    end
  end

  // timer prescale chain: predivider then fixed scaler
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      scCnt  <= '0;
    end else if (strb.loadWr) begin
      preCnt <= '0;
      scCnt  <= '0;
    end else if (running) begin
      preCnt <= baseTick ? '0 : preCnt + PRE_ONE;
      if (baseTick) scCnt <= (scCnt >= scaleMax) ? 8'd0 : scCnt + 8'd1;
    end
  end

  // free counter divider
  always_ff @(posedge clk) begin
    if (!rstN)                fdCnt <= '0;
    else if (ctlBits.freeEn)  fdCnt <= strb.freeTick ? '0 : fdCnt + FDIV_ONE;
  end

  // R8: no tick while disabled or halted
  p_halt_stops_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlBits.timerEn || (ctlBits.haltEn && dbgHalt)) |-> !strb.timerTick);

  // R9: free counter never ticks while disabled
  p_free_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctlBits.freeEn |-> !strb.freeTick);
endmodule

// File: rtl/timerDatapath.sv
module timerDatapath
  import timerPkg::*;
#(
  parameter int PREDIV_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlFields_t          ctlBits,
  input  logic [PREDIV_W-1:0] preDiv,
  input  strobes_t            strb,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  output logic                irqOut
);
  logic [REG_W-1:0] valReg;
  logic [REG_W-1:0] reloadReg;
  logic [REG_W-1:0] freeCnt;
  logic [REG_W-1:0] effVal;
  logic [REG_W-1:0] effReload;
  logic [REG_W-1:0] nextDown;
  logic             rawIrq;
  logic             atZero;
  logic             setIrq;
  logic             maskedIrq;

  assign effVal    = ctlBits.width32 ? valReg    : {{HALF_W{1'b0}}, valReg[HALF_W-1:0]};
  assign effReload = ctlBits.width32 ? reloadReg : {{HALF_W{1'b0}}, reloadReg[HALF_W-1:0]};
  assign atZero    = (effVal == '0);
  assign nextDown  = ctlBits.width32 ? (valReg - 32'd1)
                   : {{HALF_W{1'b0}}, valReg[HALF_W-1:0] - 16'd1};
  assign setIrq    = strb.timerTick && atZero && !strb.loadWr;
  assign maskedIrq = rawIrq && ctlBits.irqEn;
  assign irqOut    = maskedIrq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valReg    <= '0;
      reloadReg <= '0;
    end else begin
      if (strb.loadWr)          valReg <= regWrData;
      else if (strb.timerTick)  valReg <= atZero ? effReload : nextDown;
      if (strb.loadWr || strb.reloadWr) reloadReg <= regWrData;
    end
  end

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)             rawIrq <= 1'b0;
    else if (setIrq)       rawIrq <= 1'b1;
    else if (strb.clrWr)   rawIrq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              freeCnt <= '0;
    else if (strb.freeTick) freeCnt <= freeCnt + 32'd1;
  end

  always_comb begin
    case (regAddr)
      IDX_LOAD, IDX_RELOAD: regRdData = effReload;
      IDX_VALUE:  regRdData = effVal;
      IDX_CTRL:   regRdData = {8'd0, ctlBits.freeDiv, 6'd0, ctlBits.freeEn, ctlBits.haltEn,
                               ctlBits.timerEn, 1'b0, ctlBits.irqEn, 1'b0,
                               ctlBits.scaleSel, ctlBits.width32, 1'b0};
      IDX_RAW:    regRdData = {31'd0, rawIrq};
      IDX_MASKED: regRdData = {31'd0, maskedIrq};
      IDX_PREDIV: regRdData = {{(REG_W-PREDIV_W){1'b0}}, preDiv};
      IDX_FREE:   regRdData = freeCnt;
      default:    regRdData = '0;
    endcase
  end

  // R2: load write lands in the counter
  p_load_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWr |=> (valReg == $past(regWrData)));

  // R4: a tick at zero raises the flag and restarts from reload
  p_wrap_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.timerTick && atZero && !strb.loadWr) |=> (rawIrq && valReg == $past(effReload)));

  // R7: a clear write with no coincident wrap drops the flag
  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrWr && !(strb.timerTick && atZero)) |=> !rawIrq);

  // R9: free counter holds between ticks
  p_free_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.freeTick |=> $stable(freeCnt));
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import timerPkg::*;
#(
  parameter int PREDIV_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              dbgHalt,
  output logic              irqOut
);
  ctlFields_t          ctlBits;
  strobes_t            strb;
  logic [PREDIV_W-1:0] preDiv;

  timerCtrl #(.PREDIV_W(PREDIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .dbgHalt(dbgHalt),
    .ctlBits(ctlBits), .preDiv(preDiv), .strb(strb)
  );

  timerDatapath #(.PREDIV_W(PREDIV_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctlBits(ctlBits), .preDiv(preDiv), .strb(strb),
    .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  // R7: interrupt output is gated by the enable bit
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctlBits.irqEn |-> !irqOut);
endmodule

// File: tb/prescaled_timer_tb_top.sv
module prescaled_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        dbgHalt = 1'b0;
  logic        irqOut;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prescaled_timer dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .dbgHalt(dbgHalt), .irqOut(irqOut)
  );

  function automatic logic [31:0] mkCtl(bit w32, logic [1:0] sc, bit ie, bit te,
                                        bit he, bit fe, logic [7:0] fd);
    return {8'd0, fd, 6'd0, fe, he, te, 1'b0, ie, 1'b0, sc, w32, 1'b0};
  endfunction

  function automatic int expPeriod(int p, int code, int v);
    int s;
    s = (code == 0) ? 1 : (code == 1) ? 16 : 256;
    return (p + 1) * s * (v + 1);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wrReg(logic [3:0] a, logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic peek(logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitIrq(int start, output int n);
    n = start;
    while (!irqOut && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic runPeriod(int v, int p, int code, bit w32, string tag);
    int n;
    int ev;
    ev = expPeriod(p, code, w32 ? v : (v & 16'hFFFF));
    wrReg(4'd2, 32'd0);
    wrReg(4'd3, 32'd0);
    wrReg(4'd7, p);
    wrReg(4'd0, v);
    wrReg(4'd2, mkCtl(w32, code[1:0], 1, 1, 0, 0, 8'd0));
    waitIrq(0, n);
    check(n == ev, {tag, " R3 first period"}, n, ev);
    if (ev >= 2) begin
      wrReg(4'd3, 32'd0);
      waitIrq(1, n);
      check(n == ev, {tag, " R4 repeat period"}, n, ev);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, a, b;
    int n;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int i = 0; i < 9; i++) begin
      peek(i[3:0], d);
      check(d == 0, "R1 reset register", d, 0);
    end
    check(irqOut == 1'b0, "R1 reset irq", irqOut, 0);

    // R9 free counter from reset, N=3
    wrReg(4'd2, mkCtl(0, 2'd0, 0, 0, 0, 1, 8'd3));
    repeat (40) @(negedge clk);
    peek(4'd8, d);
    check(d == 10, "R9 free count N=3", d, 10);
    wrReg(4'd2, 32'd0);
    repeat (20) @(negedge clk);
    peek(4'd8, d);
    check(d == 10, "R9 free hold when disabled", d, 10);

    // R10 read-only words and control readback
    wrReg(4'd0, 32'd77);
    peek(4'd1, a);
    wrReg(4'd1, 32'hDEAD);
    peek(4'd1, d);
    check(d == a, "R10 value read-only", d, a);
    wrReg(4'd4, 32'd1);
    peek(4'd4, d);
    check(d == 0, "R10 raw read-only", d, 0);
    wrReg(4'd8, 32'h1234);
    peek(4'd8, d);
    check(d == 10, "R10 count read-only", d, 10);
    wrReg(4'd2, 32'hFFFF_FFFF);
    peek(4'd2, d);
    check(d == 32'h00FF_03AE, "R10 control readback", d, 32'h00FF_03AE);
    wrReg(4'd2, 32'd0);

    // R2 load/readback and R5 width
    wrReg(4'd0, 32'h0001_2345);
    peek(4'd1, d);
    check(d == 32'h2345, "R5 16-bit value read", d, 32'h2345);
    wrReg(4'd2, mkCtl(1, 2'd0, 0, 0, 0, 0, 8'd0));
    peek(4'd1, d);
    check(d == 32'h0001_2345, "R2 32-bit value read", d, 32'h0001_2345);
    peek(4'd0, d);
    check(d == 32'h0001_2345, "R2 reload from load", d, 32'h0001_2345);

    // directed periods
    runPeriod(0, 0, 0, 1, "v0");
    runPeriod(7, 0, 0, 1, "v7");
    runPeriod(3, 2, 1, 1, "div16");
    runPeriod(1, 0, 2, 1, "div256");
    runPeriod(32'h0001_0003, 0, 0, 0, "R5 width16");

    // R4 reload-only write takes effect at next wrap
    wrReg(4'd2, 32'd0);
    wrReg(4'd3, 32'd0);
    wrReg(4'd7, 32'd0);
    wrReg(4'd0, 32'd5);
    wrReg(4'd2, mkCtl(1, 2'd0, 1, 1, 0, 0, 8'd0));
    wrReg(4'd6, 32'd2);
    waitIrq(1, n);
    check(n == 6, "R4 reload write leaves current count", n, 6);
    wrReg(4'd3, 32'd0);
    waitIrq(1, n);
    check(n == 3, "R4 reload used at wrap", n, 3);

    // R6 load zero while running
    wrReg(4'd0, 32'd100);
    wrReg(4'd3, 32'd0);
    repeat (5) @(negedge clk);
    wrReg(4'd0, 32'd0);
    waitIrq(0, n);
    check(n == 1, "R6 load zero irq", n, 1);

    // R11 stop and clear
    wrReg(4'd2, 32'd0);
    wrReg(4'd3, 32'd0);
    check(irqOut == 1'b0, "R11 irq after stop", irqOut, 0);
    wrReg(4'd0, 32'd40);
    peek(4'd1, a);
    repeat (10) @(negedge clk);
    peek(4'd1, b);
    check(a == b, "R11 counter frozen", b, a);
    check(a == 40, "R11 stopped load value", a, 40);

    // R7 masking and clear
    wrReg(4'd0, 32'd50);
    wrReg(4'd2, mkCtl(1, 2'd0, 0, 1, 0, 0, 8'd0));
    repeat (60) @(negedge clk);
    peek(4'd4, d);
    check(d == 1, "R7 raw set while masked", d, 1);
    peek(4'd5, d);
    check(d == 0, "R7 masked word low", d, 0);
    check(irqOut == 1'b0, "R7 irqOut low when masked", irqOut, 0);
    wrReg(4'd3, 32'h55);
    peek(4'd4, d);
    check(d == 0, "R7 clear by any write", d, 0);

    // R8 debug halt
    dbgHalt = 1'b1;
    wrReg(4'd2, mkCtl(1, 2'd0, 0, 1, 1, 0, 8'd0));
    wrReg(4'd0, 32'd1000);
    repeat (20) @(negedge clk);
    peek(4'd1, d);
    check(d == 1000, "R8 halted counter", d, 1000);
    dbgHalt = 1'b0;
    repeat (10) @(negedge clk);
    peek(4'd1, d);
    check(d == 990, "R8 resumes after halt", d, 990);
    wrReg(4'd2, mkCtl(1, 2'd0, 0, 0, 0, 0, 8'd0));
    peek(4'd1, a);
    repeat (10) @(negedge clk);
    peek(4'd1, b);
    check(a == b, "R8 disabled counter holds", b, a);

    // R9 steady-state free counter ratios
    for (int k = 0; k < 3; k++) begin
      int nd;
      nd = $urandom % 12;
      wrReg(4'd2, mkCtl(0, 2'd0, 0, 0, 0, 1, nd[7:0]));
      repeat (300) @(negedge clk);
      peek(4'd8, a);
      repeat (5 * (nd + 1)) @(negedge clk);
      peek(4'd8, b);
      check(b - a == 5, "R9 free ratio", b - a, 5);
    end

    // R3 random sweep
    for (int k = 0; k < 10; k++) begin
      int v, p, c;
      v = $urandom % 12;
      p = $urandom % 4;
      c = $urandom % 2;
      runPeriod(v, p, c, 1, "rand");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule